// File: doc/BRIEF.md
# Locked Configuration Register Port

This block is a slave on a legacy byte-wide I/O bus. It holds a small configuration register space that software reaches through two adjacent 8-bit ports. One port takes a register number and the other carries that register's data. At reset the space is sealed. It opens only after software writes a fixed four-byte key to the number port, and it seals again when a specific value is written to a specific register.

Once the space is open, a selector register picks which device bank the upper register numbers address. The block implements the global registers and one device bank, the general-purpose I/O bank. The global registers are the selector, a 16-bit identifier and a revision nibble. The I/O bank holds a 16-bit I/O base address and two sets of per-group, per-line enable bytes. The bank's contents drive straight out to the I/O block as parallel buses.

Bus accesses are single-cycle strobes that carry a 16-bit address. A read result appears on `io_rdata` after the clock edge that samples the read strobe. The output holds that value until the next read of either port.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is sealed. `gpio_base` equals parameter BASE_RST. `gpio_simple_en` and `gpio_out_en` are all zero. The selector register and the number register are 0x00.
- R2: The space opens after the bytes 0x87, 0x01, 0x55, 0x55 are written in that order to the number port (address 0x2E). While the space is open, the data port (address 0x2F) reads and writes the register that the number register selects.
- R3: While sealed, a number-port write that does not match the next key byte restarts the match. A mismatching byte that equals 0x87 counts as the first key byte.
- R4: While sealed, reads of either port return 0xFF. Data-port writes and number-port writes change no register.
- R5: While open, a write to port 0x2E loads the number register, and a read of port 0x2E returns it.
- R6: While open, writing 0x02 to register 0x02 seals the space. Any other value written to register 0x02 leaves it open. Sealing keeps every register's value.
- R7: Register 0x07 is the bank selector. It is readable and writable, and bank 0x07 is the I/O bank.
- R8: Registers 0x20 and 0x21 return the high and low bytes of parameter CHIP_ID. Writes to them are ignored.
- R9: Register 0x22 returns parameter REV in bits 3:0, with zero in bits 7:4. Writes to it are ignored.
- R10: In the I/O bank, register 0x62 holds the high byte and 0x63 the low byte of the base address driven on `gpio_base`.
- R11: In the I/O bank, register 0xC0+g (g < SIMPLE_GROUPS) drives `gpio_simple_en[8g+7:8g]`. Register numbers past the last group read 0x00 and ignore writes.
- R12: In the I/O bank, register 0xC8+g (g < OE_GROUPS) drives `gpio_out_en[8g+7:8g]`.
- R13: When the selector is not 0x07, register numbers 0x30 and above read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_addr | input | 16 | I/O address of the access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| gpio_base | output | 16 | I/O base address for the GPIO block |
| gpio_simple_en | output | 8*SIMPLE_GROUPS | Per-line simple-I/O enables |
| gpio_out_en | output | 8*OE_GROUPS | Per-line output enables |

## Verification
The embedded assertions check four things on every cycle. The space opens only on a number-port write of the final key byte and seals only on the exact seal write. A read while sealed always yields 0xFF. The bank outputs never move without an open data write into the I/O bank. Other behaviour needs the bench's scenarios. These cover a key broken partway and restarted by 0x87, seal attempts with the wrong value, identifier registers that refuse writes, groups past the last one, and bank contents that are hidden when another selector value is active and come back when it is restored.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] REG_SEAL     = 8'h02;
    localparam logic [7:0] SEAL_VALUE   = 8'h02;
    localparam logic [7:0] REG_BANKSEL  = 8'h07;
    localparam logic [7:0] REG_ID_HI    = 8'h20;
    localparam logic [7:0] REG_ID_LO    = 8'h21;
    localparam logic [7:0] REG_REV      = 8'h22;
    localparam logic [7:0] BANK_FLOOR   = 8'h30;
    localparam logic [7:0] BANK_GPIO    = 8'h07;
    localparam logic [7:0] REG_BASE_HI  = 8'h62;
    localparam logic [7:0] REG_BASE_LO  = 8'h63;
    localparam logic [7:0] REG_SIMPLE0  = 8'hC0;
    localparam logic [7:0] REG_OE0      = 8'hC8;
    localparam logic [7:0] SEALED_READ  = 8'hFF;
    localparam int         KEY_LEN      = 4;

    typedef enum logic {
        SPACE_SEALED = 1'b0,
        SPACE_OPEN   = 1'b1
    } space_state_t;

    typedef struct packed {
        logic       wr_num;
        logic       wr_dat;
        logic       rd_num;
        logic       rd_dat;
        logic [7:0] data;
    } port_op_t;

    function automatic logic [7:0] key_byte(input logic [1:0] pos);
        case (pos)
            2'd0:    key_byte = 8'h87;
            2'd1:    key_byte = 8'h01;
            default: key_byte = 8'h55;
        endcase
    endfunction

endpackage

// File: rtl/sio_key_gate.sv
module sio_key_gate
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_op_t   op,
    input  logic [7:0] num_q,
    output logic       is_open
);

    localparam int          CNT_W    = $clog2(KEY_LEN);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(KEY_LEN - 1);

    space_state_t     state_q;
    logic [CNT_W-1:0] match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SPACE_SEALED;
            match_q <= '0;
        end else begin
            case (state_q)
                SPACE_SEALED: begin
                    if (op.wr_num) begin
                        if (op.data == key_byte(match_q)) begin
                            if (match_q == LAST_POS) begin
                                state_q <= SPACE_OPEN;
                                match_q <= '0;
                            end else begin
                                match_q <= match_q + CNT_W'(1);
                            end
                        end else if (op.data == key_byte(2'd0)) begin
                            match_q <= CNT_W'(1);
                        end else begin
                            match_q <= '0;
                        end
                    end
                end
                default: begin
                    if (op.wr_dat && num_q == REG_SEAL && op.data == SEAL_VALUE)
                        state_q <= SPACE_SEALED;
                end
            endcase
        end
    end

    assign is_open = (state_q == SPACE_OPEN);

    // R2
    open_only_on_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(is_open) |-> $past(op.wr_num && op.data == 8'h55));

    // R6
    seal_only_on_code_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(is_open) |-> $past(op.wr_dat && num_q == 8'h02 && op.data == 8'h02));

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] CHIP_ID       = 16'hA51C,
    parameter logic [3:0]  REV           = 4'h3,
    parameter logic [15:0] BASE_RST      = 16'h0A00,
    parameter int          SIMPLE_GROUPS = 5,
    parameter int          OE_GROUPS     = 8,
    localparam int         SIMPLE_W      = 8 * SIMPLE_GROUPS,
    localparam int         OE_W          = 8 * OE_GROUPS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [7:0]          num,
    input  logic [7:0]          wdata,
    output logic [7:0]          rd_data,
    output logic [15:0]         base,
    output logic [SIMPLE_W-1:0] simple_bus,
    output logic [OE_W-1:0]     oe_bus
);

    logic [7:0]  banksel_q;
    logic [15:0] base_q;
    logic        in_gpio;

    assign in_gpio = (banksel_q == BANK_GPIO) && (num >= BANK_FLOOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            banksel_q <= '0;
            base_q    <= BASE_RST;
        end else if (wr_en) begin
            if (num == REG_BANKSEL)
                banksel_q <= wdata;
            if (in_gpio && num == REG_BASE_HI)
                base_q[15:8] <= wdata;
            if (in_gpio && num == REG_BASE_LO)
                base_q[7:0] <= wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < SIMPLE_GROUPS; g++) begin : g_simple
            localparam logic [7:0] MY_NUM = REG_SIMPLE0 + 8'(g);
            always_ff @(posedge clk) begin
                if (rst)
                    simple_bus[8*g +: 8] <= '0;
                else if (wr_en && in_gpio && num == MY_NUM)
                    simple_bus[8*g +: 8] <= wdata;
            end
        end
        for (g = 0; g < OE_GROUPS; g++) begin : g_oe
            localparam logic [7:0] MY_NUM = REG_OE0 + 8'(g);
            always_ff @(posedge clk) begin
                if (rst)
                    oe_bus[8*g +: 8] <= '0;
                else if (wr_en && in_gpio && num == MY_NUM)
                    oe_bus[8*g +: 8] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rd_data = 8'h00;
        case (num)
            REG_BANKSEL: rd_data = banksel_q;
            REG_ID_HI:   rd_data = CHIP_ID[15:8];
            REG_ID_LO:   rd_data = CHIP_ID[7:0];
            REG_REV:     rd_data = {4'h0, REV};
            default:     rd_data = 8'h00;
        endcase
        if (in_gpio) begin
            if (num == REG_BASE_HI) rd_data = base_q[15:8];
            if (num == REG_BASE_LO) rd_data = base_q[7:0];
            for (int s = 0; s < SIMPLE_GROUPS; s++)
                if (num == REG_SIMPLE0 + 8'(s)) rd_data = simple_bus[8*s +: 8];
            for (int o = 0; o < OE_GROUPS; o++)
                if (num == REG_OE0 + 8'(o)) rd_data = oe_bus[8*o +: 8];
        end
    end

    assign base = base_q;

    // R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(base) && $stable(simple_bus) && $stable(oe_bus)));

    // R13
    bank_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && banksel_q != 8'h07) |=> ($stable(base) && $stable(simple_bus) && $stable(oe_bus)));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] NUM_PORT      = 16'h002E,
    parameter logic [15:0] DAT_PORT      = 16'h002F,
    parameter logic [15:0] CHIP_ID       = 16'hA51C,
    parameter logic [3:0]  REV           = 4'h3,
    parameter logic [15:0] BASE_RST      = 16'h0A00,
    parameter int          SIMPLE_GROUPS = 5,
    parameter int          OE_GROUPS     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       io_wr,
    input  logic                       io_rd,
    input  logic [15:0]                io_addr,
    input  logic [7:0]                 io_wdata,
    output logic [7:0]                 io_rdata,
    output logic [15:0]                gpio_base,
    output logic [8*SIMPLE_GROUPS-1:0] gpio_simple_en,
    output logic [8*OE_GROUPS-1:0]     gpio_out_en
);

    port_op_t   op;
    logic       is_open;
    logic [7:0] num_q;
    logic [7:0] bank_rd;

    always_comb begin
        op.wr_num = io_wr && (io_addr == NUM_PORT);
        op.wr_dat = io_wr && (io_addr == DAT_PORT);
        op.rd_num = io_rd && (io_addr == NUM_PORT);
        op.rd_dat = io_rd && (io_addr == DAT_PORT);
        op.data   = io_wdata;
    end

    sio_key_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .num_q   (num_q),
        .is_open (is_open)
    );

    sio_reg_bank #(
        .CHIP_ID       (CHIP_ID),
        .REV           (REV),
        .BASE_RST      (BASE_RST),
        .SIMPLE_GROUPS (SIMPLE_GROUPS),
        .OE_GROUPS     (OE_GROUPS)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (op.wr_dat && is_open),
        .num        (num_q),
        .wdata      (io_wdata),
        .rd_data    (bank_rd),
        .base       (gpio_base),
        .simple_bus (gpio_simple_en),
        .oe_bus     (gpio_out_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q    <= '0;
            io_rdata <= SEALED_READ;
        end else begin
            if (op.wr_num && is_open)
                num_q <= io_wdata;
            if (op.rd_num)
                io_rdata <= is_open ? num_q : SEALED_READ;
            else if (op.rd_dat)
                io_rdata <= is_open ? bank_rd : SEALED_READ;
        end
    end

    // R4
    sealed_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((io_rd && (io_addr == NUM_PORT || io_addr == DAT_PORT)) && !is_open)
        |=> io_rdata == 8'hFF);

endmodule

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PN = 16'h002E;
    localparam logic [15:0] PD = 16'h002F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] gpio_base;
    logic [39:0] gpio_simple_en;
    logic [63:0] gpio_out_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_port dut (
        .clk            (clk),
        .rst            (rst),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_addr        (io_addr),
        .io_wdata       (io_wdata),
        .io_rdata       (io_rdata),
        .gpio_base      (gpio_base),
        .gpio_simple_en (gpio_simple_en),
        .gpio_out_en    (gpio_out_en)
    );

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic setreg(input logic [7:0] n, input logic [7:0] d);
        wr(PN, n);
        wr(PD, d);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic getreg(input logic [7:0] n, input logic [7:0] e, input string tag);
        wr(PN, n);
        rd(PD, e, tag);
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] e, input string tag);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, e);
        end
    endtask

    task automatic send_key();
        wr(PN, 8'h87); wr(PN, 8'h01); wr(PN, 8'h55); wr(PN, 8'h55);
    endtask

    // monitor: pops the expected read value once the design has registered it
    initial begin
        forever begin
            @(posedge clk);
            if (io_rd && !rst) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({56'h0, io_rdata}, {56'h0, e}, t);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk({48'h0, gpio_base}, 64'h0A00, "R1 base");
        chk({24'h0, gpio_simple_en}, 64'h0, "R1 simple");
        chk(gpio_out_en, 64'h0, "R1 oe");
        // R4 sealed reads and ignored writes
        rd(PD, 8'hFF, "R4 sealed data read");
        rd(PN, 8'hFF, "R4 sealed num read");
        wr(PN, 8'h07); wr(PD, 8'h07);
        // R3 broken key keeps it sealed
        wr(PN, 8'h87); wr(PN, 8'h01); wr(PN, 8'h55); wr(PN, 8'h20); wr(PN, 8'h55);
        rd(PD, 8'hFF, "R3 broken key");
        // R3 restart on 0x87 mid-sequence
        wr(PN, 8'h87); wr(PN, 8'h01); send_key();
        rd(PN, 8'h00, "R3 R5 open num reads 0");
        rd(PD, 8'h00, "R2 open data read");
        getreg(8'h07, 8'h00, "R4 sealed writes left banksel");
        // R8 identifier
        getreg(8'h20, 8'hA5, "R8 id hi");
        getreg(8'h21, 8'h1C, "R8 id lo");
        wr(PD, 8'hFF);
        getreg(8'h21, 8'h1C, "R8 id write ignored");
        // R9 revision
        getreg(8'h22, 8'h03, "R9 rev");
        wr(PD, 8'hF0);
        getreg(8'h22, 8'h03, "R9 rev write ignored");
        // R13 bank hidden while selector is 0
        setreg(8'hC8, 8'hAA);
        chk(gpio_out_en, 64'h0, "R13 oe untouched");
        getreg(8'h62, 8'h00, "R13 base hidden");
        // R7 selector
        setreg(8'h07, 8'h07);
        getreg(8'h07, 8'h07, "R7 banksel");
        // R10 base
        getreg(8'h62, 8'h0A, "R10 base hi reset");
        getreg(8'h63, 8'h00, "R10 base lo reset");
        setreg(8'h62, 8'h12); setreg(8'h63, 8'h34);
        chk({48'h0, gpio_base}, 64'h1234, "R10 base out");
        // R11 simple enables
        setreg(8'hC0, 8'h5A); setreg(8'hC4, 8'hC3);
        chk({24'h0, gpio_simple_en}, 64'hC3_0000_005A, "R11 simple out");
        getreg(8'hC4, 8'hC3, "R11 simple read");
        setreg(8'hC5, 8'hFF);
        getreg(8'hC5, 8'h00, "R11 past last group");
        chk({24'h0, gpio_simple_en}, 64'hC3_0000_005A, "R11 simple unchanged");
        // R12 output enables
        setreg(8'hC8, 8'h81); setreg(8'hCF, 8'h7E);
        chk(gpio_out_en, 64'h7E00_0000_0000_0081, "R12 oe out");
        getreg(8'hCF, 8'h7E, "R12 oe read");
        // R13 other selector hides bank
        setreg(8'h07, 8'h08);
        getreg(8'hC8, 8'h00, "R13 oe hidden");
        wr(PD, 8'h00);
        chk(gpio_out_en, 64'h7E00_0000_0000_0081, "R13 write ignored");
        setreg(8'h07, 8'h07);
        getreg(8'hC8, 8'h81, "R13 bank restored");
        // R6 seal
        setreg(8'h02, 8'h01);
        rd(PN, 8'h02, "R6 R5 wrong value stays open");
        wr(PD, 8'h02);
        rd(PD, 8'hFF, "R6 sealed data");
        rd(PN, 8'hFF, "R6 sealed num");
        chk({48'h0, gpio_base}, 64'h1234, "R6 base retained");
        send_key();
        getreg(8'h63, 8'h34, "R6 reopen retained");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL monitor actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule